// File: doc/BRIEF.md
# Full-Period Galois Sequence Generator

This block is a free-running pseudo-random state sequencer built on a one-to-many (Galois) shift register. The plain form of such a register can never reach the all-zeros state, so it cycles through 2^n−1 values. This block adds a small correction term to the feedback that splices all-zeros into the cycle. The register therefore walks through every one of the 2^n values of its width before it repeats. No state can lock it up.

The width is fixed at elaboration, anywhere from 2 to 32 bits. The feedback polynomial for that width comes from a constant table inside the block, and a width outside the supported range stops elaboration. The block has only a clock, an active-high asynchronous reset and the registered state as output. Reset puts it at all-zeros, and from there it steps once per rising clock edge. Typical uses are pattern generation, exhaustive address walks and cheap counters where the order of the values does not matter.

Top module: `fullPeriodLfsr`

## Requirements
- R1: While `rst` is high the output is all zeros. Asserting `rst` between clock edges clears the output at once, without waiting for a clock edge.
- R2: From the all-zeros state, the next state is the polynomial remainder x^n mod P(x): bit k is the coefficient of x^k of P below x^n. For the 4-bit polynomial this is 4'b0011.
- R3: From the state in which only the top bit (bit n−1) is set, the next state is all zeros.
- R4: From any other state, bit 0 takes the old top bit, and each bit k (1 ≤ k ≤ n−1) takes old bit k−1. Bit k is also inverted when the old top bit is 1 and P(x) has a term x^k.
- R5: Between two visits to all-zeros exactly 2^n clock edges pass, and no state repeats inside one period.
- R6: The polynomial for each width is fixed: width 2 is x^2+x+1, width 3 is x^3+x+1, width 4 is x^4+x+1, width 5 is x^5+x^3+1, width 8 is x^8+x^6+x^5+x^4+1, and width 32 is x^32+x^7+x^6+x^2+1. Every other width uses a maximal-length polynomial. The first state after reset is therefore 2'b11 for width 2, 5'b01001 for width 5 and 8'h71 for width 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one step per edge |
| rst | input | 1 | Asynchronous active-high clear to all zeros |
| state | output | WIDTH | Registered sequence value |

## Verification
The hardest point to reach is the splice: the state with only the top bit set, its step into all-zeros, and the step back out. There is no seed port, so the only way there is to let the register run a full period from reset. The bench therefore runs four widths side by side (2, 4, 5 and 8 bits) for long enough that each one wraps through all-zeros at least twice. It also pulls reset in the middle of a period, between clock edges, to show that the clear is asynchronous and that the sequence restarts cleanly.

// File: rtl/lfsrFullPkg.sv
package lfsrFullPkg;

  localparam int MIN_WIDTH = 2;
  localparam int MAX_WIDTH = 32;

  // Strobes handed from the feedback control to the shift datapath
  typedef struct packed {
    logic feedback;  // value entering bit 0 and the tapped XORs
    logic lowZero;   // all bits below the top are zero
  } fbStrobe_t;

  // Mask layout: bit k (k < n-1) set means the polynomial has x^(k+1);
  // bit n-1 marks x^n and is never read by the datapath.
  function automatic logic [31:0] polyMask(input int n, input int a,
                                           input int b, input int c);
    logic [31:0] m;
    m = 32'd1 << (n - 1);
    if (a > 0) m = m | (32'd1 << (a - 1));
    if (b > 0) m = m | (32'd1 << (b - 1));
    if (c > 0) m = m | (32'd1 << (c - 1));
    return m;
  endfunction

  function automatic logic [31:0] tapMask(input int w);
    case (w)
      2:  return polyMask(2, 1, 0, 0);
      3:  return polyMask(3, 1, 0, 0);
      4:  return polyMask(4, 1, 0, 0);
      5:  return polyMask(5, 3, 0, 0);
      6:  return polyMask(6, 5, 0, 0);
      7:  return polyMask(7, 6, 0, 0);
      8:  return polyMask(8, 6, 5, 4);
      9:  return polyMask(9, 5, 0, 0);
      10: return polyMask(10, 7, 0, 0);
      11: return polyMask(11, 9, 0, 0);
      12: return polyMask(12, 11, 10, 4);
      13: return polyMask(13, 12, 11, 8);
      14: return polyMask(14, 13, 12, 2);
      15: return polyMask(15, 14, 0, 0);
      16: return polyMask(16, 15, 13, 4);
      17: return polyMask(17, 14, 0, 0);
      18: return polyMask(18, 11, 0, 0);
      19: return polyMask(19, 18, 17, 14);
      20: return polyMask(20, 17, 0, 0);
      21: return polyMask(21, 19, 0, 0);
      22: return polyMask(22, 21, 0, 0);
      23: return polyMask(23, 18, 0, 0);
      24: return polyMask(24, 23, 22, 17);
      25: return polyMask(25, 22, 0, 0);
      26: return polyMask(26, 6, 2, 1);
      27: return polyMask(27, 5, 2, 1);
      28: return polyMask(28, 25, 0, 0);
      29: return polyMask(29, 27, 0, 0);
      30: return polyMask(30, 6, 4, 1);
      31: return polyMask(31, 28, 0, 0);
      32: return polyMask(32, 7, 6, 2);
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/lfsrFeedbackCtl.sv
module lfsrFeedbackCtl
  import lfsrFullPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] stateIn,
  output fbStrobe_t        strobe
);

  localparam logic [31:0] MASK_FULL = tapMask(WIDTH);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] EXIT_ZERO = {MASK_FULL[WIDTH-2:0], 1'b1};

  // The NOR term is 1 only for all-zeros and the top-only state;
  // it turns the top-only successor into zero and lets zero leave.
  always_comb begin
    strobe.lowZero  = ~|stateIn[WIDTH-2:0];
    strobe.feedback = stateIn[WIDTH-1] ^ strobe.lowZero;
  end

  assert_zero_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && stateIn == '0) |=> (stateIn == EXIT_ZERO));

  assert_zero_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst && stateIn == TOP_ONLY) |=> (stateIn == '0));

  assert_no_lockup_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && stateIn == '0) |=> (stateIn != '0));

endmodule

// File: rtl/lfsrShiftReg.sv
module lfsrShiftReg
  import lfsrFullPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  fbStrobe_t        strobe,
  output logic [WIDTH-1:0] stateOut
);

  localparam logic [31:0] MASK_FULL = tapMask(WIDTH);

  logic [WIDTH-1:0] nextState;

  assign nextState[0] = strobe.feedback;

  // One XOR at most between neighbouring flops
  genvar k;
  generate
    for (k = 1; k < WIDTH; k++) begin : gStage
      if (MASK_FULL[k-1]) begin : gTap
        assign nextState[k] = stateOut[k-1] ^ strobe.feedback;
      end else begin : gPass
        assign nextState[k] = stateOut[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) stateOut <= '0;
    else     stateOut <= nextState;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |-> (stateOut == '0));

  assert_bit0_source_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !strobe.lowZero) |=> (stateOut[0] == $past(stateOut[WIDTH-1])));

endmodule

// File: rtl/fullPeriodLfsr.sv
module fullPeriodLfsr
  import lfsrFullPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state
);

  generate
    if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : gBadWidth
      $error("fullPeriodLfsr: WIDTH must lie in 2..32");
    end
  endgenerate

  fbStrobe_t        fbStrobe;
  logic [WIDTH-1:0] regState;

  lfsrFeedbackCtl #(.WIDTH(WIDTH)) uCtl (
    .clk     (clk),
    .rst     (rst),
    .stateIn (regState),
    .strobe  (fbStrobe)
  );

  lfsrShiftReg #(.WIDTH(WIDTH)) uPath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (fbStrobe),
    .stateOut (regState)
  );

  assign state = regState;

endmodule

// File: tb/sim_fullPeriodLfsr.sv
module sim_fullPeriodLfsr;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_INST   = 4;
  localparam int NSTEPS     = 600;
  localparam int WID  [NUM_INST] = '{4, 2, 5, 8};
  // coefficients of P(x) below x^n, bit k = x^k (from R6)
  localparam logic [31:0] LOWC [NUM_INST] = '{32'h3, 32'h3, 32'h9, 32'h71};

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic monOn = 1'b0;
  bit   finished = 1'b0;
  int   total = 0;
  int   bad = 0;

  logic [3:0] q4;
  logic [1:0] q2;
  logic [4:0] q5;
  logic [7:0] q8;
  logic [31:0] obs [NUM_INST];

  always #(CLK_PERIOD/2) clk = ~clk;

  fullPeriodLfsr #(.WIDTH(4)) u0 (.clk(clk), .rst(rst), .state(q4));
  fullPeriodLfsr #(.WIDTH(2)) u1 (.clk(clk), .rst(rst), .state(q2));
  fullPeriodLfsr #(.WIDTH(5)) u2 (.clk(clk), .rst(rst), .state(q5));
  fullPeriodLfsr #(.WIDTH(8)) u3 (.clk(clk), .rst(rst), .state(q8));

  assign obs[0] = {28'd0, q4};
  assign obs[1] = {30'd0, q2};
  assign obs[2] = {27'd0, q5};
  assign obs[3] = {24'd0, q8};

  logic [31:0] expQ [NUM_INST][$];
  logic [31:0] prevObs [NUM_INST];
  int          stepCnt [NUM_INST];
  int          lastZero [NUM_INST];
  int          zeroHits [NUM_INST];
  bit [255:0]  seen [NUM_INST];

  task automatic check(input bit ok, input string tag, input int inst,
                       input logic [31:0] got, input logic [31:0] want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s inst=%0d got=%h exp=%h", tag, inst, got, want);
    end
  endtask

  // Reference step written from R2..R4 as polynomial arithmetic
  function automatic logic [31:0] refStep(input int w, input logic [31:0] low,
                                          input logic [31:0] s);
    logic [31:0] top;
    logic [31:0] src;
    logic [32:0] t;
    top = 32'd1 << (w - 1);
    if (s == top) return 32'd0;
    src = (s == 32'd0) ? top : s;
    t = {1'b0, src} << 1;
    if (t[w]) t = t ^ (33'd1 << w) ^ {1'b0, low};
    return t[31:0];
  endfunction

  task automatic driveExpected();
    for (int i = 0; i < NUM_INST; i++) begin
      logic [31:0] cur;
      cur = 32'd0;
      expQ[i].delete();
      for (int n = 0; n < NSTEPS; n++) begin
        cur = refStep(WID[i], LOWC[i], cur);
        expQ[i].push_back(cur);
      end
      prevObs[i]  = 32'd0;
      stepCnt[i]  = 0;
      lastZero[i] = 0;
      zeroHits[i] = 0;
      seen[i]     = '0;
      seen[i][0]  = 1'b1;
    end
  endtask

  // Monitor: pops the scoreboard and tracks period and uniqueness
  always @(negedge clk) begin
    if (monOn) begin
      for (int i = 0; i < NUM_INST; i++) begin
        logic [31:0] want;
        logic [31:0] topOnly;
        string tag;
        topOnly = 32'd1 << (WID[i] - 1);
        want = (expQ[i].size() > 0) ? expQ[i].pop_front() : 32'hdead_beef;
        if (prevObs[i] == 32'd0)         tag = "R2";
        else if (prevObs[i] == topOnly)  tag = "R3";
        else                             tag = "R4";
        check(obs[i] == want, tag, i, obs[i], want);
        stepCnt[i]++;
        if (stepCnt[i] == 1)
          check(obs[i] == LOWC[i], "R6 first state", i, obs[i], LOWC[i]);
        if (obs[i] == 32'd0) begin
          zeroHits[i]++;
          check((stepCnt[i] - lastZero[i]) == (1 << WID[i]), "R5 period", i,
                stepCnt[i] - lastZero[i], 1 << WID[i]);
          lastZero[i] = stepCnt[i];
          seen[i]     = '0;
          seen[i][0]  = 1'b1;
        end else begin
          check(!seen[i][obs[i][7:0]], "R5 repeat", i, obs[i], 32'd0);
          seen[i][obs[i][7:0]] = 1'b1;
        end
        prevObs[i] = obs[i];
      end
    end
  end

  task automatic finishRun();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1 rst = 1'b1;
    #6;
    for (int i = 0; i < NUM_INST; i++)
      check(obs[i] == 32'd0, "R1 reset", i, obs[i], 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NUM_INST; i++)
      check(obs[i] == 32'd0, "R1 held", i, obs[i], 32'd0);

    driveExpected();
    rst = 1'b0;
    #1 monOn = 1'b1;
    repeat (NSTEPS) @(negedge clk);
    #1 monOn = 1'b0;

    for (int i = 0; i < NUM_INST; i++)
      check(zeroHits[i] >= 2, "R5 wraps", i, zeroHits[i], 2);

    // asynchronous clear in the middle of a period
    #2 rst = 1'b1;
    #1;
    for (int i = 0; i < NUM_INST; i++)
      check(obs[i] == 32'd0, "R1 async", i, obs[i], 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NUM_INST; i++)
      check(obs[i] == 32'd0, "R1 held", i, obs[i], 32'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NUM_INST; i++)
      check(obs[i] == LOWC[i], "R2 restart", i, obs[i], LOWC[i]);
    @(negedge clk);
    check(obs[0] == 32'h6, "R4 second step", 0, obs[0], 32'h6);

    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

endmodule